// File: doc/BRIEF.md
# Preemptive Multi-Channel DMA Arbiter

This block decides which of several DMA channels may use a single shared transfer engine. Each channel selects one trigger source: a software strobe, an event input, a peripheral request line, or none. A trigger from the selected source sets that channel's pending flag. From the pending channels the arbiter grants exactly one to the engine. It picks the highest 2-bit priority level first. Among channels at that level it rotates, starting after the channel that was granted last.

The engine reports two things: the end of each single-beat burst (`burst_done`) and the completion of the active channel's block (`block_done`). The grant is re-evaluated only at those reports, or while no channel holds the grant. A higher-priority request can therefore take over only between bursts. A channel that loses the grant this way keeps its pending flag. It resumes its unfinished block when it is granted again.

Top module: `dma_arbiter`

## Requirements
- R1: Channel i's trigger source is the 2-bit code `trig_sel[2i+1:2i]`. Code 0 selects `sw_trig[i]`, 1 selects `evt_in[i]`, 2 selects `per_req[i]`, and 3 disables the channel's triggering. A pulse on a source that is not selected has no effect on `pending`.
- R2: A trigger from the selected source in cycle t sets `pending[i]` from cycle t+1. The flag then stays set until it is cleared as R3 states.
- R3: `pending[i]` clears only after a cycle in which `block_done` is high and `grant[i]` is high. If the channel's own trigger arrives in that same cycle, the flag stays set.
- R4: `grant` is one-hot or all zero. A granted channel is always pending.
- R5: At an arbitration point the grant goes to a channel at the highest priority level present. Channel i's level is `chan_prio[2i+1:2i]`, and 3 is the highest level.
- R6: Within the winning level, the search starts at the channel index one above the channel granted last and wraps from NCH-1 to 0. After reset the search starts at channel 0.
- R7: Arbitration points are cycles with `burst_done` high, cycles with `block_done` high, and cycles with `grant` all zero. In any other cycle `grant` holds its value, so a higher-priority trigger preempts the active channel only at a burst boundary.
- R8: The decision uses the pending state as updated in the same cycle, and the new grant appears in the next cycle. When `grant` is zero and a channel is pending, or a trigger arrives, a grant appears one cycle later.
- R9: While `rst_n` is low, `grant` and `pending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_sel | input | 2*NCH | Per-channel trigger source code |
| chan_prio | input | 2*NCH | Per-channel priority level |
| sw_trig | input | NCH | Software trigger strobes |
| evt_in | input | NCH | Event trigger inputs |
| per_req | input | NCH | Peripheral request lines |
| burst_done | input | 1 | Engine finished one burst of the active channel |
| block_done | input | 1 | Engine finished the active channel's block |
| grant | output | NCH | One-hot active channel, or zero |
| pending | output | NCH | Pending request flags |

## Verification
Two events can land in the same cycle: the active channel's `block_done`, which clears its flag, and a fresh trigger on that same channel. A second case is a burst boundary that coincides with a new trigger on another channel, which then enters the decision at once. Both are provoked by one phase with heavy trigger traffic and frequent block completions, and by a long random phase. A behavioural model, written with loops over channel indices, predicts `pending` and `grant` in every cycle. Each cycle's outputs are compared against that prediction.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    TSRC_SW   = 2'd0,
    TSRC_EVT  = 2'd1,
    TSRC_PER  = 2'd2,
    TSRC_NONE = 2'd3
  } tsrc_e;
endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dma_arb_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       sw,
  input  logic       evt,
  input  logic       per,
  output logic       hit
);
  always_comb begin
    case (tsrc_e'(sel))
      TSRC_SW:  hit = sw;
      TSRC_EVT: hit = evt;
      TSRC_PER: hit = per;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_pend_bank.sv
module dma_pend_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend_nxt,
  output logic [NCH-1:0] pend_q
);
  logic pend_en;

  // a new trigger outranks the completion clear
  always_comb begin
    pend_nxt = hit | (pend_q & ~clr);
    pend_en  = |(hit | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_nxt;
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 8,
  parameter int PW  = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]    cand,
  input  logic [NCH*PW-1:0] prio,
  input  logic [IW-1:0]     last_idx,
  output logic              valid,
  output logic [IW-1:0]     idx,
  output logic [NCH-1:0]    onehot
);
  localparam int NLVL = 1 << PW;

  logic [PW-1:0]  top_lvl;
  logic [NCH-1:0] lvl_mask;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      for (int i = 0; i < NCH; i++) begin
        if (cand[i] && prio[i*PW +: PW] == PW'(l)) top_lvl = PW'(l);
      end
    end
    for (int i = 0; i < NCH; i++) begin
      lvl_mask[i] = cand[i] && (prio[i*PW +: PW] == top_lvl);
    end
  end

  always_comb begin
    valid  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = int'(last_idx) + k;
      if (j >= NCH) j = j - NCH;
      if (!valid && lvl_mask[j]) begin
        valid     = 1'b1;
        idx       = IW'(j);
        onehot[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 8,
  parameter int PW  = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NCH-1:0] trig_sel,
  input  logic [PW*NCH-1:0] chan_prio,
  input  logic [NCH-1:0]  sw_trig,
  input  logic [NCH-1:0]  evt_in,
  input  logic [NCH-1:0]  per_req,
  input  logic            burst_done,
  input  logic            block_done,
  output logic [NCH-1:0]  grant,
  output logic [NCH-1:0]  pending
);
  logic [NCH-1:0] hit, clr, pend_nxt, pick_oh;
  logic [NCH-1:0] grant_q, grant_d;
  logic [IW-1:0]  last_q, last_d, pick_idx;
  logic           pick_vld, arb_ev, last_en;

  for (genvar c = 0; c < NCH; c++) begin : g_trig
    dma_trig_sel u_sel (
      .sel (trig_sel[2*c +: 2]),
      .sw  (sw_trig[c]),
      .evt (evt_in[c]),
      .per (per_req[c]),
      .hit (hit[c])
    );
  end

  assign clr = grant_q & {NCH{block_done}};

  dma_pend_bank #(.NCH(NCH)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr      (clr),
    .pend_nxt (pend_nxt),
    .pend_q   (pending)
  );

  dma_prio_pick #(.NCH(NCH), .PW(PW)) u_pick (
    .cand     (pend_nxt),
    .prio     (chan_prio),
    .last_idx (last_q),
    .valid    (pick_vld),
    .idx      (pick_idx),
    .onehot   (pick_oh)
  );

  // decide only at burst boundaries, block ends, or when idle
  always_comb begin
    arb_ev  = ~|grant_q | burst_done | block_done;
    grant_d = pick_oh;
    last_en = arb_ev & pick_vld;
    last_d  = pick_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grant_q <= '0;
    else if (arb_ev) grant_q <= grant_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= IW'(NCH - 1);
    else if (last_en) last_q <= last_d;
  end

  assign grant = grant_q;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           burst_done,
  input logic           block_done,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] pending
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pending) == '0); // R4

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && !burst_done && !block_done) |=> $stable(grant)); // R7

  AST_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pending) && !(|grant)) |=> (|grant)); // R8

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & $past(pending & ~(grant & {NCH{block_done}})))
              == $past(pending & ~(grant & {NCH{block_done}})))); // R3
endmodule

bind dma_arbiter dma_arb_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_done (burst_done),
  .block_done (block_done),
  .grant      (grant),
  .pending    (pending)
);

// File: tb/tb_dma_arbiter.sv
module tb_dma_arbiter;
  localparam int NCH    = 8;
  localparam int PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2*NCH-1:0] trig_sel;
  logic [2*NCH-1:0] chan_prio;
  logic [NCH-1:0]  sw_trig, evt_in, per_req;
  logic            burst_done, block_done;
  logic [NCH-1:0]  grant, pending;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R9";

  // reference model state
  logic [NCH-1:0] m_pend;
  int             m_grant;
  int             m_last;

  always #(PERIOD/2) clk = ~clk;

  dma_arbiter #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .chan_prio(chan_prio),
    .sw_trig(sw_trig), .evt_in(evt_in), .per_req(per_req),
    .burst_done(burst_done), .block_done(block_done),
    .grant(grant), .pending(pending)
  );

  function automatic int pick(logic [NCH-1:0] c, int last);
    for (int lv = 3; lv >= 0; lv--) begin
      for (int k = 1; k <= NCH; k++) begin
        int j;
        j = (last + k) % NCH;
        if (c[j] && int'(chan_prio[2*j +: 2]) == lv) return j;
      end
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend  = '0;
      m_grant = -1;
      m_last  = NCH - 1;
    end else begin
      logic [NCH-1:0] np;
      for (int i = 0; i < NCH; i++) begin
        bit h;
        case (trig_sel[2*i +: 2])
          2'd0:    h = sw_trig[i];
          2'd1:    h = evt_in[i];
          2'd2:    h = per_req[i];
          default: h = 1'b0;
        endcase
        np[i] = h | (m_pend[i] & !(block_done && m_grant == i));
      end
      if (m_grant < 0 || burst_done || block_done) begin
        m_grant = pick(np, m_last);
        if (m_grant >= 0) m_last = m_grant;
      end
      m_pend = np;
    end
  end

  task automatic compare();
    logic [NCH-1:0] eg;
    eg = '0;
    if (m_grant >= 0) eg[m_grant] = 1'b1;
    n_cmp++;
    if (grant !== eg || pending !== m_pend) begin
      n_bad++;
      $display("FAIL %s t=%0t grant=%b exp=%b pending=%b exp=%b",
               cur_req, $time, grant, eg, pending, m_pend);
    end
  endtask

  function automatic bit roll(int pct);
    return ($urandom % 100) < pct;
  endfunction

  // one cycle per iteration: compare at the falling edge, then drive
  task automatic run(int n, int p_trig, int p_bd, int p_kd, bit new_cfg);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      if (new_cfg) begin
        trig_sel  = 16'($urandom);
        chan_prio = 16'($urandom);
      end
      for (int i = 0; i < NCH; i++) begin
        sw_trig[i] = roll(p_trig);
        evt_in[i]  = roll(p_trig);
        per_req[i] = roll(p_trig);
      end
      burst_done = roll(p_bd);
      block_done = roll(p_kd);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    trig_sel = '0; chan_prio = '0;
    sw_trig = '0; evt_in = '0; per_req = '0;
    burst_done = 1'b0; block_done = 1'b0;
    cur_req = "R9";
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;

    cur_req = "R1";   // source selection, disabled code 3
    run(200, 15, 30, 30, 1'b1);
    cur_req = "R2";   // no engine reports: flags and grant hold
    run(20, 20, 0, 0, 1'b0);
    run(40, 0, 0, 0, 1'b0);
    cur_req = "R5";   // distinct levels, drain
    trig_sel = '0;
    chan_prio = 16'b00_01_10_11_00_01_10_11;
    run(100, 10, 50, 25, 1'b0);
    cur_req = "R6";   // one level, bursts only: rotation
    chan_prio = '0;
    run(5, 80, 0, 0, 1'b0);
    run(60, 0, 100, 0, 1'b0);
    cur_req = "R3";   // completion colliding with own trigger
    run(300, 60, 50, 60, 1'b0);
    cur_req = "R7";   // preemption only at burst boundaries
    run(400, 5, 20, 5, 1'b1);
    cur_req = "R8";   // idle wakeup
    run(300, 2, 50, 50, 1'b0);
    cur_req = "R4";   // long mixed run
    run(3000, 10, 40, 15, 1'b1);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog %s expired", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule